// File: doc/BRIEF.md
# SCSI Controller Interrupt Status Unit

This block keeps the status byte, the interrupt-cause byte, the sequence-step value, the FIFO flag byte and the three transfer-count bytes of a small SCSI bus controller. It drives one level-sensitive interrupt line to the host. The bus-phase, DMA and command engines around it send single-cycle completion pulses. For each pulse the block loads a fixed pattern into these registers and raises the interrupt.

The interrupt-pending flag is bit 7 of the status byte, and the interrupt line is that bit. Raising the interrupt when it is already pending changes nothing, and the same holds for lowering it when it is already clear. The host reads the registers through a byte-wide port with a 4-bit address and one cycle of latency. A read of the cause register is the host's acknowledge: it drops the interrupt and wipes the two error flags. A synchronous device-reset pulse puts every register back to its default. After that reset the high count byte returns an identification code.

Top module: `scsi_irq_status`

## Requirements
- R1: After reset, `irq` is 0 and every register reads 0, except the high count byte (address 2), which reads 0x04.
- R2: `irq` always equals bit 7 of the status byte (address 4). The bit reads 0x80 exactly when the line is high, and raising the interrupt while it is already pending leaves it high.
- R3: A read of the cause register (address 5) returns its current value. From the next cycle, status bits 7 (pending), 6 (gross error) and 5 (parity error) are 0 and `irq` is low. All other status bits are kept.
- R4: `ev_bad_tgt` sets the status byte to 0x00 and then raises the interrupt, so status reads 0x80. It also sets cause to 0x20 and the sequence step (address 6) to 0.
- R5: `ev_cmd_done` sets status to 0x10 ORed with `cmd_phase` in bits 2:0, then raises the interrupt. It sets cause to 0x18 (bus service 0x10 plus function complete 0x08) and the sequence step to 4.
- R6: `ev_dma_done` ORs 0x10 into status and keeps all other status bits. It sets cause to 0x10, and sets to 0 the sequence step, the flag byte (address 7) and the low and middle count bytes (addresses 0 and 1). Then it raises the interrupt.
- R7: `ev_bus_rst` sets cause to 0x80. It raises the interrupt only when `cfg_rst_quiet` is 0. Otherwise `irq` stays as it was.
- R8: `soft_rst` returns every register to the R1 state in the next cycle, with `irq` low, whatever else is asserted.
- R9: When several events arrive in one cycle, only one is applied. The order of precedence is `soft_rst`, `ev_bus_rst`, `ev_bad_tgt`, `ev_cmd_done`, `ev_dma_done`.
- R10: If a cause-register read and an event fall in the same cycle, the read returns the values from before the event. The event's values and a high `irq` appear in the next cycle.
- R11: `rd_data` shows the register selected in the cycle when `rd_en` is high, one clock later. Addresses 3 and 8–15 read 0.
- R12: `err_gross` sets status bit 6 and `err_parity` sets status bit 5. `cnt_load` loads `cnt_val[7:0]` into the low count byte, `cnt_val[15:8]` into the middle count byte, and `flag_val` into the flag byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Device reset pulse |
| ev_bus_rst | input | 1 | Bus reset command pulse |
| ev_bad_tgt | input | 1 | Selection of an absent target |
| ev_cmd_done | input | 1 | Command or status phase finished |
| cmd_phase | input | 3 | Phase bits stored with ev_cmd_done |
| ev_dma_done | input | 1 | DMA transfer finished |
| err_gross | input | 1 | Gross error report |
| err_parity | input | 1 | Parity error report |
| cnt_load | input | 1 | Load count and flag bytes |
| cnt_val | input | 16 | Middle and low count bytes |
| flag_val | input | 8 | FIFO flag byte value |
| cfg_rst_quiet | input | 1 | Suppress the bus-reset interrupt |
| rd_en | input | 1 | Host read strobe |
| rd_addr | input | 4 | Host register address |
| rd_data | output | 8 | Registered read data |
| irq | output | 1 | Level interrupt to host |

## Verification
The bench targets the acknowledge that lands in the same cycle as a new event. A design that applied the clear after the event would lose that interrupt, and one that sampled after the update would return the new cause instead of the old one. It fires events in pairs to expose a wrong precedence, which shows up as the wrong cause byte. It checks that DMA completion keeps the existing status bits while clearing the count and flag bytes. It also checks that a suppressed bus reset updates the cause byte and leaves `irq` low.

// File: rtl/scsi_irq_pkg.sv
package scsi_irq_pkg;
    localparam int ADDR_W = 4;
    localparam int N_EV   = 5;

    localparam int ST_PEND  = 7;
    localparam int ST_GROSS = 6;
    localparam int ST_PAR   = 5;
    localparam int ST_TC    = 4;

    localparam logic [7:0] CAUSE_BUS_RST = 8'h80;
    localparam logic [7:0] CAUSE_DISC    = 8'h20;
    localparam logic [7:0] CAUSE_SVC     = 8'h10;
    localparam logic [7:0] CAUSE_FDONE   = 8'h08;

    localparam logic [ADDR_W-1:0] A_CNT_LO  = 4'h0;
    localparam logic [ADDR_W-1:0] A_CNT_MID = 4'h1;
    localparam logic [ADDR_W-1:0] A_CNT_HI  = 4'h2;
    localparam logic [ADDR_W-1:0] A_STAT    = 4'h4;
    localparam logic [ADDR_W-1:0] A_CAUSE   = 4'h5;
    localparam logic [ADDR_W-1:0] A_STEP    = 4'h6;
    localparam logic [ADDR_W-1:0] A_FLAGS   = 4'h7;

    // grant vector index = precedence, 0 is highest
    localparam int G_SOFT = 0;
    localparam int G_BRST = 1;
    localparam int G_BADT = 2;
    localparam int G_CMD  = 3;
    localparam int G_DMA  = 4;

    typedef struct packed {
        logic [7:0] stat;
        logic [7:0] cause;
        logic [2:0] step;
        logic [7:0] flags;
        logic [7:0] cnt_lo;
        logic [7:0] cnt_mid;
        logic [7:0] cnt_hi;
    } regs_t;

    typedef struct packed {
        regs_t      r;
        logic [7:0] rd_data;
    } state_t;
endpackage

// File: rtl/scsi_evt_arb.sv
module scsi_evt_arb #(
    parameter int N = 5
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    logic [N:0] blocked;
    assign blocked[0] = 1'b0;
    for (genvar i = 0; i < N; i++) begin : g_chain
        assign blocked[i+1] = blocked[i] | req[i];
        assign gnt[i]       = req[i] & ~blocked[i];
    end
endmodule

// File: rtl/scsi_reg_next.sv
module scsi_reg_next
    import scsi_irq_pkg::*;
#(
    parameter logic [7:0] CHIP_ID  = 8'h04,
    parameter logic [2:0] STEP_CMD = 3'd4
) (
    input  regs_t           cur,
    input  logic [N_EV-1:0] gnt,
    input  logic [2:0]      phase,
    input  logic            quiet,
    input  logic            ack,
    input  logic            err_g,
    input  logic            err_p,
    input  logic            cnt_load,
    input  logic [15:0]     cnt_val,
    input  logic [7:0]      flag_val,
    output regs_t           nxt
);
    always_comb begin
        nxt = cur;
        if (ack) begin
            nxt.stat[ST_PEND]  = 1'b0;
            nxt.stat[ST_GROSS] = 1'b0;
            nxt.stat[ST_PAR]   = 1'b0;
        end
        if (cnt_load) begin
            nxt.cnt_lo  = cnt_val[7:0];
            nxt.cnt_mid = cnt_val[15:8];
            nxt.flags   = flag_val;
        end
        if (gnt[G_BRST]) begin
            nxt.cause = CAUSE_BUS_RST;
            if (!quiet && !nxt.stat[ST_PEND]) nxt.stat[ST_PEND] = 1'b1;
        end
        if (gnt[G_BADT]) begin
            nxt.stat  = 8'h00;
            nxt.cause = CAUSE_DISC;
            nxt.step  = 3'd0;
            if (!nxt.stat[ST_PEND]) nxt.stat[ST_PEND] = 1'b1;
        end
        if (gnt[G_CMD]) begin
            nxt.stat        = 8'h00;
            nxt.stat[ST_TC] = 1'b1;
            nxt.stat[2:0]   = phase;
            nxt.cause       = CAUSE_SVC | CAUSE_FDONE;
            nxt.step        = STEP_CMD;
            if (!nxt.stat[ST_PEND]) nxt.stat[ST_PEND] = 1'b1;
        end
        if (gnt[G_DMA]) begin
            nxt.stat[ST_TC] = 1'b1;
            nxt.cause       = CAUSE_SVC;
            nxt.step        = 3'd0;
            nxt.flags       = 8'h00;
            nxt.cnt_lo      = 8'h00;
            nxt.cnt_mid     = 8'h00;
            if (!nxt.stat[ST_PEND]) nxt.stat[ST_PEND] = 1'b1;
        end
        if (err_g) nxt.stat[ST_GROSS] = 1'b1;
        if (err_p) nxt.stat[ST_PAR]   = 1'b1;
        if (gnt[G_SOFT]) begin
            nxt        = '0;
            nxt.cnt_hi = CHIP_ID;
        end
    end
endmodule

// File: rtl/scsi_rd_mux.sv
module scsi_rd_mux
    import scsi_irq_pkg::*;
(
    input  regs_t             regs,
    input  logic [ADDR_W-1:0] addr,
    output logic [7:0]        data
);
    always_comb begin
        unique case (addr)
            A_CNT_LO:  data = regs.cnt_lo;
            A_CNT_MID: data = regs.cnt_mid;
            A_CNT_HI:  data = regs.cnt_hi;
            A_STAT:    data = regs.stat;
            A_CAUSE:   data = regs.cause;
            A_STEP:    data = {5'b0, regs.step};
            A_FLAGS:   data = regs.flags;
            default:   data = 8'h00;
        endcase
    end
endmodule

// File: rtl/scsi_irq_status.sv
module scsi_irq_status
    import scsi_irq_pkg::*;
#(
    parameter logic [7:0] CHIP_ID  = 8'h04,
    parameter logic [2:0] STEP_CMD = 3'd4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              ev_bus_rst,
    input  logic              ev_bad_tgt,
    input  logic              ev_cmd_done,
    input  logic [2:0]        cmd_phase,
    input  logic              ev_dma_done,
    input  logic              err_gross,
    input  logic              err_parity,
    input  logic              cnt_load,
    input  logic [15:0]       cnt_val,
    input  logic [7:0]        flag_val,
    input  logic              cfg_rst_quiet,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              irq
);
    state_t          state_d, state_q;
    logic [N_EV-1:0] req, gnt;
    regs_t           regs_nxt;
    logic [7:0]      rd_sel;
    logic            ack;

    assign req = {ev_dma_done, ev_cmd_done, ev_bad_tgt, ev_bus_rst, soft_rst};
    assign ack = rd_en && (rd_addr == A_CAUSE);

    scsi_evt_arb #(.N(N_EV)) u_arb (.req(req), .gnt(gnt));

    scsi_reg_next #(.CHIP_ID(CHIP_ID), .STEP_CMD(STEP_CMD)) u_next (
        .cur(state_q.r), .gnt(gnt), .phase(cmd_phase), .quiet(cfg_rst_quiet),
        .ack(ack), .err_g(err_gross), .err_p(err_parity), .cnt_load(cnt_load),
        .cnt_val(cnt_val), .flag_val(flag_val), .nxt(regs_nxt)
    );

    scsi_rd_mux u_rd (.regs(state_q.r), .addr(rd_addr), .data(rd_sel));

    always_comb begin
        state_d         = state_q;
        state_d.r       = regs_nxt;
        state_d.rd_data = rd_en ? rd_sel : state_q.rd_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q          <= '0;
            state_q.r.cnt_hi <= CHIP_ID;
        end else begin
            state_q <= state_d;
        end
    end

    assign rd_data = state_q.rd_data;
    assign irq     = state_q.r.stat[ST_PEND];
endmodule

// File: rtl/scsi_irq_status_chk.sv
module scsi_irq_status_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       soft_rst,
    input logic       ev_bus_rst,
    input logic       ev_bad_tgt,
    input logic       ev_cmd_done,
    input logic       ev_dma_done,
    input logic       err_gross,
    input logic       err_parity,
    input logic       cfg_rst_quiet,
    input logic       rd_en,
    input logic [3:0] rd_addr,
    input logic       irq,
    input logic [7:0] cause,
    input logic [2:0] step,
    input logic [7:0] cnt_lo,
    input logic [7:0] cnt_mid,
    input logic [7:0] cnt_hi
);
    logic any_ev;
    assign any_ev = soft_rst | ev_bus_rst | ev_bad_tgt | ev_cmd_done | ev_dma_done;

    AST_ACK_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == 4'h5 && !any_ev) |=> !irq); // R3
    AST_BAD_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_bad_tgt && !soft_rst && !ev_bus_rst) |=> (irq && cause == 8'h20 && step == 3'd0)); // R4
    AST_CMD_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_cmd_done && !soft_rst && !ev_bus_rst && !ev_bad_tgt) |=> (irq && cause == 8'h18 && step == 3'd4)); // R5
    AST_DMA_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_dma_done && !soft_rst && !ev_bus_rst && !ev_bad_tgt && !ev_cmd_done)
        |=> (irq && cause == 8'h10 && cnt_lo == 8'h00 && cnt_mid == 8'h00)); // R6
    AST_BUS_RST_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_bus_rst && !soft_rst && !cfg_rst_quiet) |=> (irq && cause == 8'h80)); // R7
    AST_BUS_RST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_bus_rst && !soft_rst && cfg_rst_quiet && !irq) |=> !irq); // R7
    AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (!irq && cnt_hi == 8'h04 && cause == 8'h00)); // R8
    AST_NO_SPURIOUS_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && !ev_bus_rst && !ev_bad_tgt && !ev_cmd_done && !ev_dma_done) |=> !irq); // R2
endmodule

bind scsi_irq_status scsi_irq_status_chk u_chk (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .ev_bus_rst(ev_bus_rst),
    .ev_bad_tgt(ev_bad_tgt), .ev_cmd_done(ev_cmd_done), .ev_dma_done(ev_dma_done),
    .err_gross(err_gross), .err_parity(err_parity), .cfg_rst_quiet(cfg_rst_quiet),
    .rd_en(rd_en), .rd_addr(rd_addr), .irq(irq), .cause(state_q.r.cause),
    .step(state_q.r.step), .cnt_lo(state_q.r.cnt_lo), .cnt_mid(state_q.r.cnt_mid),
    .cnt_hi(state_q.r.cnt_hi)
);

// File: tb/scsi_irq_status_tb.sv
module scsi_irq_status_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 0, ev_bus_rst = 0, ev_bad_tgt = 0, ev_cmd_done = 0, ev_dma_done = 0;
    logic [2:0]  cmd_phase = '0;
    logic        err_gross = 0, err_parity = 0, cnt_load = 0, cfg_rst_quiet = 0;
    logic [15:0] cnt_val = '0;
    logic [7:0]  flag_val = '0;
    logic        rd_en = 0;
    logic [3:0]  rd_addr = '0;
    logic [7:0]  rd_data;
    logic        irq;
    int          n_chk = 0, n_bad = 0;
    logic        done = 0;

    always #4 clk = ~clk;

    scsi_irq_status u_dut (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .ev_bus_rst(ev_bus_rst),
        .ev_bad_tgt(ev_bad_tgt), .ev_cmd_done(ev_cmd_done), .cmd_phase(cmd_phase),
        .ev_dma_done(ev_dma_done), .err_gross(err_gross), .err_parity(err_parity),
        .cnt_load(cnt_load), .cnt_val(cnt_val), .flag_val(flag_val),
        .cfg_rst_quiet(cfg_rst_quiet), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .irq(irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic clr_all();
        soft_rst = 0; ev_bus_rst = 0; ev_bad_tgt = 0; ev_cmd_done = 0; ev_dma_done = 0;
        err_gross = 0; err_parity = 0; cnt_load = 0; rd_en = 0;
    endtask

    task automatic step();
        @(negedge clk);
        clr_all();
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] v);
        @(negedge clk);
        rd_en = 1; rd_addr = a;
        @(negedge clk);
        rd_en = 0;
        v = rd_data;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        check("R1 irq", {7'b0, irq}, 8'h00);
        rd(4'h2, v); check("R1 cnt_hi", v, 8'h04);
        rd(4'h4, v); check("R1 stat", v, 8'h00);
        rd(4'h5, v); check("R1 cause", v, 8'h00);
        rd(4'h0, v); check("R1 cnt_lo", v, 8'h00);
        rd(4'h7, v); check("R1 flags", v, 8'h00);
    endtask

    task automatic t_bad_target();
        logic [7:0] v;
        @(negedge clk); cnt_load = 1; cnt_val = 16'hABCD; flag_val = 8'h5A;
        step();
        rd(4'h0, v); check("R12 cnt_lo", v, 8'hCD);
        rd(4'h1, v); check("R12 cnt_mid", v, 8'hAB);
        @(negedge clk); ev_bad_tgt = 1;
        step();
        check("R4 irq", {7'b0, irq}, 8'h01);
        rd(4'h4, v); check("R2 R4 stat", v, 8'h80);
        rd(4'h6, v); check("R4 step", v, 8'h00);
        rd(4'h5, v); check("R4 cause", v, 8'h20);
        check("R3 irq after ack", {7'b0, irq}, 8'h00);
    endtask

    task automatic t_ack_errors();
        logic [7:0] v;
        @(negedge clk); err_gross = 1; err_parity = 1;
        step();
        rd(4'h4, v); check("R12 err bits", v, 8'h60);
        rd(4'h5, v);
        rd(4'h4, v); check("R3 errors cleared", v, 8'h00);
    endtask

    task automatic t_cmd_done();
        logic [7:0] v;
        @(negedge clk); ev_cmd_done = 1; cmd_phase = 3'b011;
        step();
        rd(4'h4, v); check("R5 stat", v, 8'h93);
        rd(4'h6, v); check("R5 step", v, 8'h04);
        @(negedge clk); ev_cmd_done = 1; cmd_phase = 3'b011;
        step();
        check("R2 raise idempotent", {7'b0, irq}, 8'h01);
        rd(4'h5, v); check("R5 cause", v, 8'h18);
        rd(4'h4, v); check("R3 keeps TC and phase", v, 8'h13);
    endtask

    task automatic t_dma_done();
        logic [7:0] v;
        @(negedge clk); cnt_load = 1; cnt_val = 16'h1234; flag_val = 8'h07;
        step();
        @(negedge clk); err_parity = 1;
        step();
        @(negedge clk); ev_dma_done = 1;
        step();
        rd(4'h4, v); check("R6 stat keeps bits", v, 8'hB3);
        rd(4'h0, v); check("R6 cnt_lo", v, 8'h00);
        rd(4'h1, v); check("R6 cnt_mid", v, 8'h00);
        rd(4'h7, v); check("R6 flags", v, 8'h00);
        rd(4'h6, v); check("R6 step", v, 8'h00);
        rd(4'h5, v); check("R6 cause", v, 8'h10);
    endtask

    task automatic t_bus_rst();
        logic [7:0] v;
        @(negedge clk); ev_bus_rst = 1; cfg_rst_quiet = 1;
        step();
        check("R7 quiet irq", {7'b0, irq}, 8'h00);
        rd(4'h5, v); check("R7 quiet cause", v, 8'h80);
        @(negedge clk); ev_bus_rst = 1; cfg_rst_quiet = 0;
        step();
        check("R7 irq", {7'b0, irq}, 8'h01);
        rd(4'h5, v);
    endtask

    task automatic t_priority();
        logic [7:0] v;
        @(negedge clk); ev_bad_tgt = 1; ev_cmd_done = 1;
        step();
        rd(4'h5, v); check("R9 bad over cmd", v, 8'h20);
        @(negedge clk); ev_bus_rst = 1; ev_bad_tgt = 1;
        step();
        rd(4'h5, v); check("R9 busrst over bad", v, 8'h80);
        @(negedge clk); ev_cmd_done = 1; ev_dma_done = 1; cmd_phase = 3'b001;
        step();
        rd(4'h6, v); check("R9 cmd over dma step", v, 8'h04);
        rd(4'h5, v); check("R9 cmd over dma cause", v, 8'h18);
        @(negedge clk); ev_cmd_done = 1;
        step();
        @(negedge clk); soft_rst = 1; ev_bus_rst = 1; ev_dma_done = 1; err_gross = 1;
        step();
        check("R8 irq", {7'b0, irq}, 8'h00);
        rd(4'h4, v); check("R8 stat", v, 8'h00);
        rd(4'h2, v); check("R8 cnt_hi", v, 8'h04);
        rd(4'h5, v); check("R8 cause", v, 8'h00);
    endtask

    task automatic t_same_cycle();
        logic [7:0] v;
        @(negedge clk); ev_cmd_done = 1; cmd_phase = 3'b010;
        step();
        @(negedge clk); rd_en = 1; rd_addr = 4'h5; ev_dma_done = 1;
        step();
        check("R10 old cause returned", rd_data, 8'h18);
        check("R10 irq after", {7'b0, irq}, 8'h01);
        rd(4'h4, v); check("R10 stat", v, 8'h92);
        rd(4'h5, v); check("R10 new cause", v, 8'h10);
    endtask

    task automatic t_unmapped();
        logic [7:0] v;
        rd(4'h3, v);  check("R11 addr3", v, 8'h00);
        rd(4'h8, v);  check("R11 addr8", v, 8'h00);
        rd(4'hF, v);  check("R11 addr15", v, 8'h00);
        rd(4'h2, v);  check("R11 cnt_hi", v, 8'h04);
        @(negedge clk);
        check("R11 data held", rd_data, 8'h04);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_bad_target();
        t_ack_errors();
        t_cmd_done();
        t_dma_done();
        t_bus_rst();
        t_priority();
        t_same_cycle();
        t_unmapped();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule